// File: doc/BRIEF.md
# Transceiver Tile Reset Sequencer

This block coordinates the resets of a two-channel serial transceiver tile. It accepts one tile-wide reset request and four reset requests for each channel: clock-data-recovery (CDR), RX protocol logic (RX PCS), RX elastic buffer and TX protocol logic (TX PCS). All requests are asynchronous and act on their rising edge. Each request is brought into the reference-clock domain and becomes a timed reset enable for the subcomponents it covers.

A tile request resets every stage of both channels. The stages are released in a fixed order: a PLL settle step, then CDR, then RX PCS together with the RX buffer, then TX PCS. Each step lasts one quarter of the configured sequence length. A per-channel request restarts only its own subtree. A CDR request also holds the RX PCS. The step timer runs only while the PLL-lock input is high. Each channel has one ready flag, which stays low while any stage of that channel is held or still waiting for release.

The sequence length is a parameter in reference-clock cycles. For example, 12000 cycles is 120 µs at 100 MHz.

Top module: `xrs_top`

## Requirements
- R1: When `rst_n` is released, a full sequence runs. Directly after reset, every stage output of both channels is high and both ready flags are low. The ready flags rise on the 4*S-th clock edge after reset release, where S = SEQ_CYCLES/4, provided the lock input is high throughout.
- R2: Each request input passes through a two-flop synchronizer and is acted on only at its rising edge. The affected outputs change on the third rising clock edge after the input goes high. An input held high does not trigger a second time.
- R3: A tile request asserts every stage output of both channels. With lock high, all stages stay asserted for 2*S edges (PLL step plus CDR step). CDR is then released, the RX PCS and RX buffer are released S edges later, and TX PCS is released S edges after that. Each channel's state is reported as mask {tx, rxbuf, rxpcs, cdr}.
- R4: A CDR request for a channel asserts that channel's CDR and RX PCS outputs (mask 0011). CDR is released after S edges and RX PCS after 2*S edges. The RX buffer and TX PCS outputs are not touched.
- R5: An RX PCS request asserts only RX PCS (mask 0010). An RX buffer request asserts only the RX buffer (mask 0100). A TX request asserts only TX PCS (mask 1000). Each of these lasts S edges.
- R6: A per-channel request leaves the stage outputs and the ready flag of the other channel unchanged.
- R7: A channel's ready flag is low exactly while any of that channel's stages is asserted or waiting, and is high otherwise.
- R8: The step timer advances only while `pll_lock` is high. While lock is low, every stage that is held stays held. After lock rises, the current step ends on the S-th edge.
- R9: A new request that arrives while a step is running restarts the step timer. The affected stages are released S edges after the new request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low power-on reset |
| pll_lock | input | 1 | Lock indication from the shared PLL |
| tile_rst_req | input | 1 | Asynchronous tile-wide reset request, rising-edge active |
| cdr_rst_req | input | NUM_CH | Per-channel CDR reset request |
| rxpcs_rst_req | input | NUM_CH | Per-channel RX PCS reset request |
| rxbuf_rst_req | input | NUM_CH | Per-channel RX elastic buffer reset request |
| txpcs_rst_req | input | NUM_CH | Per-channel TX PCS reset request |
| cdr_rst_o | output | NUM_CH | CDR reset enable |
| rxpcs_rst_o | output | NUM_CH | RX PCS reset enable |
| rxbuf_rst_o | output | NUM_CH | RX buffer reset enable |
| txpcs_rst_o | output | NUM_CH | TX PCS reset enable |
| ready_o | output | NUM_CH | Channel reset done flag |

## Verification
A table issues each request kind on each channel in turn. For each one it samples the stage mask one edge before acceptance, at acceptance, and one edge either side of the expected release. This separates the subtree of each kind and catches any leakage into the other channel. Directed cases then cover:
- the staggered release of a tile reset, which exposes a wrong stage order;
- a stalled PLL lock, which separates a gated timer from a free-running one;
- a repeated request part-way through a step, which separates a restart from a continuation;
- a request held high, which separates edge detection from level detection.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
    localparam int NSTG      = 5;
    localparam int STG_PLL   = 0;
    localparam int STG_CDR   = 1;
    localparam int STG_RXPCS = 2;
    localparam int STG_RXBUF = 3;
    localparam int STG_TX    = 4;
    localparam int REQ_PER_CH = 4;

    typedef logic [NSTG-1:0] stg_mask_t;

    localparam stg_mask_t M_ALL   = '1;
    localparam stg_mask_t M_CDR   = stg_mask_t'((1 << STG_CDR) | (1 << STG_RXPCS));
    localparam stg_mask_t M_RXPCS = stg_mask_t'(1 << STG_RXPCS);
    localparam stg_mask_t M_RXBUF = stg_mask_t'(1 << STG_RXBUF);
    localparam stg_mask_t M_TX    = stg_mask_t'(1 << STG_TX);
endpackage

// File: rtl/xrs_req_sync.sv
module xrs_req_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] rise_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = async_i;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign rise_o = sy_q.s2 & ~sy_q.s3;

    // R2: a detected edge lasts exactly one cycle per bit
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_o) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/xrs_chan_seq.sv
module xrs_chan_seq
    import xrs_pkg::*;
#(
    parameter int STEP_CYC = 3000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pll_lock,
    input  stg_mask_t req_bits,
    output stg_mask_t pend_o,
    output logic      ready_o
);
    localparam int TW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(STEP_CYC - 1);

    typedef struct packed {
        stg_mask_t     pend;
        logic [TW-1:0] timer;
        logic          ready;
    } seq_t;

    seq_t      st_d, st_q;
    stg_mask_t grp;

    // stage group owning the current step, earliest pending first
    always_comb begin
        grp = '0;
        if (st_q.pend[STG_PLL])
            grp[STG_PLL] = 1'b1;
        else if (st_q.pend[STG_CDR])
            grp[STG_CDR] = 1'b1;
        else if (st_q.pend[STG_RXPCS] || st_q.pend[STG_RXBUF]) begin
            grp[STG_RXPCS] = st_q.pend[STG_RXPCS];
            grp[STG_RXBUF] = st_q.pend[STG_RXBUF];
        end else
            grp[STG_TX] = st_q.pend[STG_TX];
    end

    always_comb begin
        st_d = st_q;
        if (|req_bits) begin
            st_d.pend  = st_q.pend | req_bits;
            st_d.timer = '0;
        end else if (|st_q.pend) begin
            if (!pll_lock) begin
                st_d.timer = '0;
            end else if (st_q.timer == T_LAST) begin
                st_d.pend  = st_q.pend & ~grp;
                st_d.timer = '0;
            end else begin
                st_d.timer = st_q.timer + 1'b1;
            end
        end
        st_d.ready = (st_d.pend == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pend  <= M_ALL;
            st_q.timer <= '0;
            st_q.ready <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o  = st_q.pend;
    assign ready_o = st_q.ready;

    // R4: CDR is never held without RX PCS
    a_r4_cdr_with_rxpcs: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend[STG_CDR] |-> st_q.pend[STG_RXPCS]);

    // R8: no release while lock is low and nothing new arrives
    a_r8_hold_no_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (!pll_lock && req_bits == '0) |=> $stable(st_q.pend));

    // R3: TX PCS is the last stage to leave reset
    a_r3_tx_last: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.pend[STG_TX]) |-> (st_q.pend[STG_RXBUF:STG_PLL] == '0));

    // R9: an accepted request is held with a fresh timer
    a_r9_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_bits) |=> (((st_q.pend & $past(req_bits)) == $past(req_bits)) && st_q.timer == '0));

    // R7: ready only when nothing is held
    a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> (pend_o == '0));
endmodule

// File: rtl/xrs_top.sv
module xrs_top
    import xrs_pkg::*;
#(
    parameter int NUM_CH     = 2,
    parameter int SEQ_CYCLES = 12000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pll_lock,
    input  logic              tile_rst_req,
    input  logic [NUM_CH-1:0] cdr_rst_req,
    input  logic [NUM_CH-1:0] rxpcs_rst_req,
    input  logic [NUM_CH-1:0] rxbuf_rst_req,
    input  logic [NUM_CH-1:0] txpcs_rst_req,
    output logic [NUM_CH-1:0] cdr_rst_o,
    output logic [NUM_CH-1:0] rxpcs_rst_o,
    output logic [NUM_CH-1:0] rxbuf_rst_o,
    output logic [NUM_CH-1:0] txpcs_rst_o,
    output logic [NUM_CH-1:0] ready_o
);
    localparam int NSTEPS   = 4;
    localparam int STEP_CYC = (SEQ_CYCLES / NSTEPS > 0) ? SEQ_CYCLES / NSTEPS : 1;
    localparam int NREQ     = 1 + REQ_PER_CH * NUM_CH;

    logic [NREQ-1:0] raw_req, rise;
    logic            tile_rise;

    assign raw_req   = {txpcs_rst_req, rxbuf_rst_req, rxpcs_rst_req, cdr_rst_req, tile_rst_req};
    assign tile_rise = rise[0];

    xrs_req_sync #(.W(NREQ)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_req),
        .rise_o  (rise)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        stg_mask_t ch_req;
        stg_mask_t ch_pend;

        assign ch_req = (tile_rise                  ? M_ALL   : '0)
                      | (rise[1 + c]                ? M_CDR   : '0)
                      | (rise[1 + NUM_CH + c]       ? M_RXPCS : '0)
                      | (rise[1 + 2 * NUM_CH + c]   ? M_RXBUF : '0)
                      | (rise[1 + 3 * NUM_CH + c]   ? M_TX    : '0);

        xrs_chan_seq #(.STEP_CYC(STEP_CYC)) u_seq (
            .clk      (clk),
            .rst_n    (rst_n),
            .pll_lock (pll_lock),
            .req_bits (ch_req),
            .pend_o   (ch_pend),
            .ready_o  (ready_o[c])
        );

        assign cdr_rst_o[c]   = ch_pend[STG_CDR];
        assign rxpcs_rst_o[c] = ch_pend[STG_RXPCS];
        assign rxbuf_rst_o[c] = ch_pend[STG_RXBUF];
        assign txpcs_rst_o[c] = ch_pend[STG_TX];
    end

    // R3: a tile request drops every ready flag on the next cycle
    a_r3_tile_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        tile_rise |=> (ready_o == '0));
endmodule

// File: tb/xrs_top_tb.sv
`timescale 1ns/1ps
module xrs_top_tb;
    localparam int NCH = 2;
    localparam int SEQ = 40;
    localparam int S   = SEQ / 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll_lock = 1'b1;
    logic tile_req = 1'b0;
    logic [NCH-1:0] cdr_req = '0, rxp_req = '0, rxb_req = '0, tx_req = '0;
    logic [NCH-1:0] cdr_o, rxp_o, rxb_o, tx_o, rdy;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    xrs_top #(.NUM_CH(NCH), .SEQ_CYCLES(SEQ)) u_dut (
        .clk(clk), .rst_n(rst_n), .pll_lock(pll_lock),
        .tile_rst_req(tile_req), .cdr_rst_req(cdr_req), .rxpcs_rst_req(rxp_req),
        .rxbuf_rst_req(rxb_req), .txpcs_rst_req(tx_req),
        .cdr_rst_o(cdr_o), .rxpcs_rst_o(rxp_o), .rxbuf_rst_o(rxb_o),
        .txpcs_rst_o(tx_o), .ready_o(rdy)
    );

    // kind[10:8] ch[7] mask{tx,rxbuf,rxpcs,cdr}[6:3] groups[2:0]
    localparam logic [10:0] VEC [6] = '{
        {3'd0, 1'b0, 4'b1111, 3'd4},
        {3'd1, 1'b0, 4'b0011, 3'd2},
        {3'd2, 1'b1, 4'b0010, 3'd1},
        {3'd3, 1'b0, 4'b0100, 3'd1},
        {3'd4, 1'b1, 4'b1000, 3'd1},
        {3'd1, 1'b1, 4'b0011, 3'd2}
    };

    function automatic logic [3:0] mask(input int c);
        return {tx_o[c], rxb_o[c], rxp_o[c], cdr_o[c]};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fire(input int kind, input int c);
        case (kind)
            0: tile_req = 1'b1;
            1: cdr_req[c] = 1'b1;
            2: rxp_req[c] = 1'b1;
            3: rxb_req[c] = 1'b1;
            default: tx_req[c] = 1'b1;
        endcase
    endtask

    task automatic drop();
        tile_req = 1'b0; cdr_req = '0; rxp_req = '0; rxb_req = '0; tx_req = '0;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset mask ch0", {4'd0, mask(0)}, 8'h0f);
        chk("R1 reset mask ch1", {4'd0, mask(1)}, 8'h0f);
        chk("R1 reset ready", {6'd0, rdy}, 8'h0);
        rst_n = 1'b1;
        step(4 * S - 1);
        chk("R1 ready before end", {6'd0, rdy}, 8'h0);
        step(1);
        chk("R1 ready after full sequence", {6'd0, rdy}, 8'h3);

        // table walk: R2 R4 R5 R6 R7
        for (int i = 0; i < 6; i++) begin
            automatic int kind = int'(VEC[i][10:8]);
            automatic int c = int'(VEC[i][7]);
            automatic int o = 1 - c;
            automatic logic [3:0] m = VEC[i][6:3];
            automatic int g = int'(VEC[i][2:0]);
            automatic logic [3:0] om = (kind == 0) ? m : 4'b0000;
            fire(kind, c);
            step(2);
            chk("R2 no change before third edge", {4'd0, mask(c)}, 8'h0);
            step(1);
            drop();
            chk("R2 R4 R5 asserted mask", {4'd0, mask(c)}, {4'd0, m});
            chk("R6 other channel mask", {4'd0, mask(o)}, {4'd0, om});
            chk("R7 ready low", {7'd0, rdy[c]}, 8'h0);
            chk("R6 other ready", {7'd0, rdy[o]}, {7'd0, kind != 0});
            if (kind == 1) begin
                step(S);
                chk("R4 cdr released first", {4'd0, mask(c)}, 8'h2);
                step(S - 1);
            end else begin
                step(g * S - 1);
            end
            chk("R4 R5 still held one edge before release", {7'd0, rdy[c]}, 8'h0);
            step(1);
            chk("R7 ready after release", {7'd0, rdy[c]}, 8'h1);
            chk("R7 mask clear", {4'd0, mask(c)}, 8'h0);
            step(4);
        end

        // R3 staggered release order
        fire(0, 0);
        step(3);
        drop();
        step(S);
        chk("R3 after pll step", {mask(1), mask(0)}, 8'hff);
        step(S);
        chk("R3 cdr released", {mask(1), mask(0)}, 8'hee);
        step(S);
        chk("R3 rx released", {mask(1), mask(0)}, 8'h88);
        step(S);
        chk("R3 tx released", {mask(1), mask(0)}, 8'h00);
        chk("R3 ready", {6'd0, rdy}, 8'h3);
        step(4);

        // R8 lock low stalls
        pll_lock = 1'b0;
        fire(3, 1);
        step(3);
        drop();
        step(3 * S);
        chk("R8 held while unlocked", {4'd0, mask(1)}, 8'h4);
        pll_lock = 1'b1;
        step(S - 1);
        chk("R8 held one edge before", {7'd0, rdy[1]}, 8'h0);
        step(1);
        chk("R8 released S edges after lock", {7'd0, rdy[1]}, 8'h1);
        step(4);

        // R9 restart
        fire(4, 0);
        step(3);
        drop();
        step(4);
        fire(4, 0);
        step(3);
        drop();
        step(3);
        chk("R9 not released at first deadline", {4'd0, mask(0)}, 8'h8);
        step(S - 4);
        chk("R9 held before restarted deadline", {7'd0, rdy[0]}, 8'h0);
        step(1);
        chk("R9 released after restart", {7'd0, rdy[0]}, 8'h1);
        step(4);

        // R2 held-high request triggers once
        tx_req[0] = 1'b1;
        step(3 + S);
        chk("R2 released while input held", {7'd0, rdy[0]}, 8'h1);
        step(2 * S);
        chk("R2 no retrigger on level", {4'd0, mask(0)}, 8'h0);
        drop();
        step(4);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule